// File: doc/BRIEF.md
# UART Host Register Interface

This block is the host-bus front end of a 16550-style UART. It decodes a three-input chip select and a 3-bit register address. Most addresses map to a single register. Two addresses map to more than one. Address 0 reaches the receive buffer on a read and the transmit holding register on a write. It reaches the divisor low byte instead when the divisor-access bit is set. Address 1 works the same way for the interrupt enable register and the divisor high byte. An address strobe input either passes the address and selects straight through or holds the values it last captured.

The block stores the line control, modem control, scratch, interrupt enable and the two divisor bytes. It runs a divisor counter that gives one 16x baud tick every N reference clocks. It combines the enabled interrupt sources into one request line and a priority-coded identification byte. The serial engines, FIFOs and modem pins sit outside the block. They supply received data, line and modem status, and pending flags. They receive single-cycle load, pop and FIFO-control strobes.

Top module: `uart_host_regs`

## Requirements
- R1: The block is selected only when cs0_i=1, cs1_i=1 and cs2_n_i=0. When it is not selected, writes change no register and rdata_o reads 0.
- R2: While adr_le_i=1, the live selects and address are used and captured. While adr_le_i=0, the captured values are used and the live pins are ignored.
- R3: With bit 7 of line control (the divisor-access bit) at 0, address 0 works as follows. A read returns rx_data_i and asserts rx_pop_o in that cycle. A write asserts tx_load_o for one cycle, with tx_data_o equal to the written byte.
- R4: With the divisor-access bit at 0, address 1 is interrupt enable. Bit 0 enables the receive-ready source and bit 1 enables the transmit-empty source. Only these two bits are stored, and bits 7:2 read as 0.
- R5: With the divisor-access bit at 1, address 0 is the divisor low byte and address 1 is the divisor high byte. The two bytes may be written in either order. These accesses produce no tx_load_o and leave interrupt enable unchanged.
- R6: Address 2 reads identification in priority order: 0x04 when receive is enabled and pending, else 0x02 when transmit-empty is enabled and pending, else 0x01. A write to address 2 asserts fcr_we_o for one cycle with fcr_o equal to the written byte.
- R7: Address 3 (line control, output on lcr_o), address 4 (modem control, output on mcr_o) and address 7 (scratch) read back the last byte written to them, whatever the divisor-access bit.
- R8: Address 5 reads lsr_i and address 6 reads msr_i. Writes to these addresses have no effect.
- R9: With a nonzero divisor N, tick16_o is high for one cycle in every N clocks (every cycle when N=1). A write to either divisor byte restarts the count.
- R10: With a divisor of 0, tick16_o stays low.
- R11: irq_o = (enable bit 0 AND rx_ready_i) OR (enable bit 1 AND thr_empty_i).
- R12: After reset, line control, modem control, scratch, interrupt enable and the divisor are all 0, so irq_o is low and no tick occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs0_i | input | 1 | Chip select, active high |
| cs1_i | input | 1 | Chip select, active high |
| cs2_n_i | input | 1 | Chip select, active low |
| adr_le_i | input | 1 | Address strobe: 1 passes and captures, 0 holds |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Write strobe, one cycle |
| rd_i | input | 1 | Read strobe, one cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register |
| rx_data_i | input | 8 | Head of receive path |
| rx_ready_i | input | 1 | Receive data pending |
| thr_empty_i | input | 1 | Transmit holding register empty |
| lsr_i | input | 8 | Line status from the engines |
| msr_i | input | 8 | Modem status from the pins |
| tx_load_o | output | 1 | Transmit holding write strobe |
| tx_data_o | output | 8 | Transmit byte |
| rx_pop_o | output | 1 | Receive buffer read strobe |
| fcr_we_o | output | 1 | FIFO control write strobe |
| fcr_o | output | 8 | FIFO control byte |
| lcr_o | output | 8 | Line control register |
| mcr_o | output | 8 | Modem control register |
| tick16_o | output | 1 | 16x baud tick |
| irq_o | output | 1 | Interrupt request |

## Verification
The checker watches several properties on every cycle. It checks that the scratch byte holds unless a selected write targets it, and that line control takes the written byte. It checks that the transmit and receive strobes never fire while the divisor-access bit is set, that a zero divisor gives no tick, and that a tick lasts one cycle for divisors above 1. It also checks that the interrupt line stays low with nothing pending. The bench scenarios cover what needs a sequence of accesses. Those are the address aliasing under both settings of the divisor-access bit, the divisor written in both byte orders, tick spacing for specific divisors, the priority of the identification byte, and the hold behaviour of the captured address.

// File: rtl/uart_host_pkg.sv
package uart_host_pkg;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_RXTX,
    SEL_IEN,
    SEL_IDFC,
    SEL_LCTL,
    SEL_MCTL,
    SEL_LSTS,
    SEL_MSTS,
    SEL_SCR,
    SEL_DIVL,
    SEL_DIVH
  } reg_sel_e;

  localparam logic [7:0] ID_NONE = 8'h01;
  localparam logic [7:0] ID_THR  = 8'h02;
  localparam logic [7:0] ID_RX   = 8'h04;

  localparam int unsigned DLAB_BIT = 7;

endpackage

// File: rtl/uart_host_decode.sv
module uart_host_decode
  import uart_host_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs0_i,
  input  logic              cs1_i,
  input  logic              cs2_n_i,
  input  logic              adr_le_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              dlab_i,
  output reg_sel_e          sel_o
);

  localparam int unsigned CS_W = 3;

  logic [CS_W-1:0]   cs_q, cs_eff;
  logic [ADDR_W-1:0] addr_q, addr_eff;
  logic              chip_en;

  // capture while strobe is high; reset value leaves the block deselected
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= '0;
      addr_q <= '0;
    end else if (adr_le_i) begin
      cs_q   <= {cs0_i, cs1_i, cs2_n_i};
      addr_q <= addr_i;
    end
  end

  assign cs_eff   = adr_le_i ? {cs0_i, cs1_i, cs2_n_i} : cs_q;
  assign addr_eff = adr_le_i ? addr_i : addr_q;
  assign chip_en  = cs_eff[2] & cs_eff[1] & ~cs_eff[0];

  always_comb begin
    sel_o = SEL_NONE;
    if (chip_en) begin
      unique case (addr_eff[2:0])
        3'd0:    sel_o = dlab_i ? SEL_DIVL : SEL_RXTX;
        3'd1:    sel_o = dlab_i ? SEL_DIVH : SEL_IEN;
        3'd2:    sel_o = SEL_IDFC;
        3'd3:    sel_o = SEL_LCTL;
        3'd4:    sel_o = SEL_MCTL;
        3'd5:    sel_o = SEL_LSTS;
        3'd6:    sel_o = SEL_MSTS;
        default: sel_o = SEL_SCR;
      endcase
    end
  end

endmodule

// File: rtl/uart_baud_div.sv
module uart_baud_div #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             restart_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic             run, wrap;

  assign run  = (div_i != '0);
  // >= keeps the counter sane if the limit drops below the count
  assign wrap = run && (cnt_q >= div_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (restart_i || !run || wrap) cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = wrap;

endmodule

// File: rtl/uart_host_irq.sv
module uart_host_irq
  import uart_host_pkg::*;
#(
  parameter int unsigned SRC_N = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic [SRC_N-1:0]  ien_i,
  input  logic              rx_ready_i,
  input  logic              thr_empty_i,
  output logic              irq_o,
  output logic [DATA_W-1:0] id_o
);

  logic [SRC_N-1:0] pend, hit;

  assign pend  = {thr_empty_i, rx_ready_i};
  assign hit   = pend & ien_i;
  assign irq_o = |hit;

  // receive outranks transmit-empty
  always_comb begin
    if (hit[0])      id_o = DATA_W'(ID_RX);
    else if (hit[1]) id_o = DATA_W'(ID_THR);
    else             id_o = DATA_W'(ID_NONE);
  end

endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
  import uart_host_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs0_i,
  input  logic              cs1_i,
  input  logic              cs2_n_i,
  input  logic              adr_le_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_ready_i,
  input  logic              thr_empty_i,
  input  logic [DATA_W-1:0] lsr_i,
  input  logic [DATA_W-1:0] msr_i,
  output logic              tx_load_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              rx_pop_o,
  output logic              fcr_we_o,
  output logic [DATA_W-1:0] fcr_o,
  output logic [DATA_W-1:0] lcr_o,
  output logic [DATA_W-1:0] mcr_o,
  output logic              tick16_o,
  output logic              irq_o
);

  localparam int unsigned DIV_W = 2 * DATA_W;
  localparam int unsigned SRC_N = 2;

  reg_sel_e          sel;
  logic [DATA_W-1:0] lcr_q, mcr_q, scr_q, id_byte;
  logic [DIV_W-1:0]  div_q;
  logic [SRC_N-1:0]  ien_q;
  logic              div_we;

  uart_host_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs0_i    (cs0_i),
    .cs1_i    (cs1_i),
    .cs2_n_i  (cs2_n_i),
    .adr_le_i (adr_le_i),
    .addr_i   (addr_i),
    .dlab_i   (lcr_q[DLAB_BIT]),
    .sel_o    (sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcr_q <= '0;
      mcr_q <= '0;
      scr_q <= '0;
      ien_q <= '0;
      div_q <= '0;
    end else if (wr_i) begin
      case (sel)
        SEL_IEN:  ien_q <= wdata_i[SRC_N-1:0];
        SEL_LCTL: lcr_q <= wdata_i;
        SEL_MCTL: mcr_q <= wdata_i;
        SEL_SCR:  scr_q <= wdata_i;
        SEL_DIVL: div_q[DATA_W-1:0] <= wdata_i;
        SEL_DIVH: div_q[DIV_W-1:DATA_W] <= wdata_i;
        default: ;
      endcase
    end
  end

  assign div_we = wr_i && (sel == SEL_DIVL || sel == SEL_DIVH);

  uart_baud_div #(.DIV_W(DIV_W)) u_baud (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .div_i     (div_q),
    .restart_i (div_we),
    .tick_o    (tick16_o)
  );

  uart_host_irq #(.SRC_N(SRC_N), .DATA_W(DATA_W)) u_irq (
    .ien_i       (ien_q),
    .rx_ready_i  (rx_ready_i),
    .thr_empty_i (thr_empty_i),
    .irq_o       (irq_o),
    .id_o        (id_byte)
  );

  always_comb begin
    unique case (sel)
      SEL_RXTX: rdata_o = rx_data_i;
      SEL_IEN:  rdata_o = {{(DATA_W-SRC_N){1'b0}}, ien_q};
      SEL_IDFC: rdata_o = id_byte;
      SEL_LCTL: rdata_o = lcr_q;
      SEL_MCTL: rdata_o = mcr_q;
      SEL_LSTS: rdata_o = lsr_i;
      SEL_MSTS: rdata_o = msr_i;
      SEL_SCR:  rdata_o = scr_q;
      SEL_DIVL: rdata_o = div_q[DATA_W-1:0];
      SEL_DIVH: rdata_o = div_q[DIV_W-1:DATA_W];
      default:  rdata_o = '0;
    endcase
  end

  assign tx_load_o = wr_i && (sel == SEL_RXTX);
  assign tx_data_o = wdata_i;
  assign rx_pop_o  = rd_i && (sel == SEL_RXTX);
  assign fcr_we_o  = wr_i && (sel == SEL_IDFC);
  assign fcr_o     = wdata_i;
  assign lcr_o     = lcr_q;
  assign mcr_o     = mcr_q;

endmodule

// File: rtl/uart_host_regs_chk.sv
module uart_host_regs_chk
  import uart_host_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [DATA_W-1:0] wdata_i,
  input reg_sel_e          sel,
  input logic [DATA_W-1:0] scr_q,
  input logic [DATA_W-1:0] lcr_q,
  input logic [DIV_W-1:0]  div_q,
  input logic              div_we,
  input logic              tick16_o,
  input logic              rx_ready_i,
  input logic              thr_empty_i,
  input logic              irq_o,
  input logic              tx_load_o,
  input logic              rx_pop_o
);

  // R7
  scr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && sel == SEL_SCR) |=> $stable(scr_q));

  // R7
  lcr_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel == SEL_LCTL) |=> (lcr_q == $past(wdata_i)));

  // R10
  div_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q == '0) |-> !tick16_o);

  // R9
  tick_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick16_o && div_q > 1 && !div_we) |=> !tick16_o);

  // R11
  irq_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_ready_i && !thr_empty_i) |-> !irq_o);

  // R3
  tx_dlab_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_o |-> !lcr_q[DLAB_BIT]);

  // R3
  rx_dlab_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |-> !lcr_q[DLAB_BIT]);

endmodule

bind uart_host_regs uart_host_regs_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_i        (wr_i),
  .wdata_i     (wdata_i),
  .sel         (sel),
  .scr_q       (scr_q),
  .lcr_q       (lcr_q),
  .div_q       (div_q),
  .div_we      (div_we),
  .tick16_o    (tick16_o),
  .rx_ready_i  (rx_ready_i),
  .thr_empty_i (thr_empty_i),
  .irq_o       (irq_o),
  .tx_load_o   (tx_load_o),
  .rx_pop_o    (rx_pop_o)
);

// File: tb/uart_host_regs_bench.sv
module uart_host_regs_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs0 = 1'b1, cs1 = 1'b1, cs2_n = 1'b0, le = 1'b1;
  logic [2:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, rdata, rx_data = '0, lsr = '0, msr = '0;
  logic rx_ready = 1'b0, thr_empty = 1'b0;
  logic tx_load, rx_pop, fcr_we, tick, irq;
  logic [7:0] tx_data, fcr, lcr, mcr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_host_regs u_uart_host_regs (
    .clk_i(clk), .rst_ni(rst_n), .cs0_i(cs0), .cs1_i(cs1), .cs2_n_i(cs2_n),
    .adr_le_i(le), .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
    .rdata_o(rdata), .rx_data_i(rx_data), .rx_ready_i(rx_ready),
    .thr_empty_i(thr_empty), .lsr_i(lsr), .msr_i(msr), .tx_load_o(tx_load),
    .tx_data_o(tx_data), .rx_pop_o(rx_pop), .fcr_we_o(fcr_we), .fcr_o(fcr),
    .lcr_o(lcr), .mcr_o(mcr), .tick16_o(tick), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    le = 1'b1; addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    le = 1'b1; addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic tick_period(output int per);
    int n = 0;
    per = -1;
    while (n < 2000) begin
      @(negedge clk); #1; n++;
      if (tick) break;
    end
    for (int k = 1; k < 2000; k++) begin
      @(negedge clk); #1;
      if (tick) begin per = k; break; end
    end
  endtask

  task automatic t_reset;
    logic [7:0] v;
    bus_rd(3, v); chk("R12 lcr", v, 0);
    bus_rd(1, v); chk("R12 ien", v, 0);
    bus_rd(4, v); chk("R12 mcr", v, 0);
    bus_rd(7, v); chk("R12 scr", v, 0);
    chk("R12 irq", irq, 0);
    begin
      int seen = 0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); #1 seen += tick; end
      chk("R10 no tick with zero divisor", seen, 0);
    end
  endtask

  task automatic t_select;
    logic [7:0] v;
    bus_wr(7, 8'h11);
    cs2_n = 1'b1; bus_wr(7, 8'h5A); #1 chk("R1 rdata deselected", rdata, 0);
    cs2_n = 1'b0; cs0 = 1'b0; bus_wr(7, 8'h6B);
    cs0 = 1'b1; cs1 = 1'b0; bus_wr(7, 8'h7C);
    cs1 = 1'b1;
    bus_rd(7, v); chk("R1 writes ignored when deselected", v, 8'h11);
  endtask

  task automatic t_plain_regs;
    logic [7:0] v;
    bus_wr(3, 8'h1B); bus_wr(4, 8'h13); bus_wr(7, 8'hA5);
    bus_rd(3, v); chk("R7 lcr readback", v, 8'h1B);
    bus_rd(4, v); chk("R7 mcr readback", v, 8'h13);
    bus_rd(7, v); chk("R7 scr readback", v, 8'hA5);
    chk("R7 lcr_o", lcr, 8'h1B);
    chk("R7 mcr_o", mcr, 8'h13);
  endtask

  task automatic t_ien;
    logic [7:0] v;
    bus_wr(1, 8'hFF);
    bus_rd(1, v); chk("R4 only two enable bits", v, 8'h03);
    bus_wr(1, 8'h02);
    bus_rd(1, v); chk("R4 enable readback", v, 8'h02);
  endtask

  task automatic t_rxtx;
    logic [7:0] v;
    @(negedge clk);
    le = 1'b1; addr = 0; wdata = 8'h77; wr = 1'b1;
    #1 chk("R3 tx_load on write", tx_load, 1);
    chk("R3 tx_data", tx_data, 8'h77);
    @(negedge clk); wr = 1'b0;
    #1 chk("R3 tx_load one cycle", tx_load, 0);
    rx_data = 8'h3C;
    @(negedge clk);
    addr = 0; rd = 1'b1;
    #1 v = rdata;
    chk("R3 rx_pop on read", rx_pop, 1);
    chk("R3 rx data", v, 8'h3C);
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic t_divisor;
    logic [7:0] v;
    int per;
    int loads = 0;
    bus_wr(1, 8'h01);
    bus_wr(3, 8'h83);
    fork
      begin bus_wr(0, 8'h03); bus_wr(1, 8'h00); end
      begin repeat (5) begin @(negedge clk); #1 loads += tx_load; end end
    join
    chk("R5 no tx_load with dlab", loads, 0);
    bus_rd(0, v); chk("R5 div low", v, 8'h03);
    bus_rd(1, v); chk("R5 div high", v, 8'h00);
    tick_period(per); chk("R9 period divisor 3", per, 3);
    // high byte first
    bus_wr(1, 8'h01); bus_wr(0, 8'h00);
    bus_rd(1, v); chk("R5 div high first", v, 8'h01);
    tick_period(per); chk("R9 period divisor 256", per, 256);
    bus_wr(1, 8'h00); bus_wr(0, 8'h0C);
    tick_period(per); chk("R9 period divisor 12", per, 12);
    bus_wr(0, 8'h01);
    tick_period(per); chk("R9 period divisor 1", per, 1);
    bus_wr(0, 8'h00);
    begin
      int seen = 0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); #1 seen += tick; end
      chk("R10 divisor zero stops tick", seen, 0);
    end
    bus_wr(3, 8'h03);
    bus_rd(1, v); chk("R5 enable untouched by divisor writes", v, 8'h01);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    bus_wr(1, 8'h03);
    rx_ready = 1'b1; thr_empty = 1'b1;
    bus_rd(2, v); chk("R6 rx outranks thr", v, 8'h04);
    chk("R11 irq both", irq, 1);
    rx_ready = 1'b0;
    bus_rd(2, v); chk("R6 thr id", v, 8'h02);
    bus_wr(1, 8'h00); rx_ready = 1'b1;
    bus_rd(2, v); chk("R6 no id when disabled", v, 8'h01);
    chk("R11 irq masked", irq, 0);
    bus_wr(1, 8'h02); thr_empty = 1'b0;
    #1 chk("R11 rx pending not enabled", irq, 0);
    thr_empty = 1'b1;
    #1 chk("R11 thr enabled pending", irq, 1);
    rx_ready = 1'b0; thr_empty = 1'b0;
    @(negedge clk);
    addr = 2; wdata = 8'hC7; wr = 1'b1;
    #1 chk("R6 fcr_we", fcr_we, 1);
    chk("R6 fcr byte", fcr, 8'hC7);
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic t_status;
    logic [7:0] v;
    lsr = 8'h61; msr = 8'hB0;
    bus_wr(5, 8'hFF); bus_wr(6, 8'hFF);
    bus_rd(5, v); chk("R8 line status", v, 8'h61);
    bus_rd(6, v); chk("R8 modem status", v, 8'hB0);
    bus_rd(7, v); chk("R8 writes leave scratch", v, 8'hA5);
  endtask

  task automatic t_strobe;
    logic [7:0] v;
    @(negedge clk); le = 1'b1; addr = 7;
    @(negedge clk); le = 1'b0; addr = 3; cs2_n = 1'b1; wdata = 8'h3E; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    #1 chk("R2 held address read", rdata, 8'h3E);
    cs2_n = 1'b0;
    bus_rd(3, v); chk("R2 live address after strobe", v, 8'h03);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_select();
    t_plain_regs();
    t_ien();
    t_rxtx();
    t_divisor();
    t_irq();
    t_status();
    t_strobe();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule